// File: doc/BRIEF.md
# Edge-Latched Complementing Scratchpad RAM

This block is a small read/write word store with an enable-strobed interface. An access begins when the active-low enable is seen going from high to low. At that moment the address is captured, and the captured address serves every cycle of the access until enable goes high again. A low write strobe during the access stores the data input. A high write strobe reads, and the output then carries the bitwise inverse of the stored word. A read leaves the stored word as it was.

All pins are sampled on one system clock, and the output is registered, so a result shows one cycle after the edge that sampled the request. The three-state output of an asynchronous memory becomes a data bus plus an active-high drive flag. The bus reads zero whenever the flag is low. The pins are plain strobes and there is no valid/ready stream. Flow control is the enable sequence itself: a new access needs a new high-to-low enable transition.

Top module: `cmpl_scratchpad`

## Requirements
- R1: At each clock edge that samples `en_n`=0 and `we_n`=0, `din` is stored at the selected address. The selected address is `addr` in the edge where the access begins and the captured address in every later edge of the same access.
- R2: One cycle after an edge that samples `en_n`=0 and `we_n`=1, `dout_oe`=1 and `dout` equals the bitwise complement of the word stored at the selected address.
- R3: The address is captured only at an edge that samples `en_n`=0 after `en_n`=1 in the previous edge. Changes on `addr` while enable stays low have no effect on the access.
- R4: One cycle after an edge that samples `en_n`=1, or `en_n`=0 with `we_n`=0, `dout_oe`=0 and `dout`=0.
- R5: With `en_n`=1 nothing is written, whatever `we_n` and `din` are.
- R6: A read does not change the stored word, so repeated reads of one location give the same value.
- R7: Within one low period of `en_n`, reads and writes may alternate freely (read-modify-write) and all of them use the same captured address.
- R8: When several writing edges occur in one access, the word holds the `din` of the last of them.
- R9: Synchronous active-high `rst` forces `dout_oe`=0 and `dout`=0, blocks writes while it is asserted, and sets the enable history to "disabled". A low `en_n` at the first edge after reset therefore starts a new access at the `addr` of that edge.
- R10: Each of the 2^`ADDR_W` locations (16 by default) holds its own `DATA_W`-bit word (4 by default), selected by the binary value of the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low memory enable; its falling edge starts an access |
| we_n | input | 1 | Active-low write strobe (high = read) |
| addr | input | ADDR_W | Word address, captured when an access starts |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Inverted read data; zero when not driven |
| dout_oe | output | 1 | High when `dout` is driven by a read |

## Verification
The bench changes `addr` in the middle of held-low accesses. A design that follows the live address instead of the captured one writes or reads the wrong word, and a later read shows it. Read-modify-write in one enable period, with the address moving between phases, catches designs that capture again on a write-strobe transition or that miss read-after-write data. A reset applied with enable held low, followed by a read, catches history that resets to "enabled", which would skip the capture and read the address left from reset. Random traffic compares every driven read against a model of the inverted contents, so a non-inverting read path shows at once, and so do outputs that stay driven during writes.

// File: rtl/scrp_pkg.sv
package scrp_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/scrp_access_ctl.sv
module scrp_access_ctl
  import scrp_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [ADDR_W-1:0] lat_addr
);

  // enable history: 1 = disabled in the previous sampled cycle
  logic en_hist;
  logic start;

  assign start    = !en_n && en_hist;
  assign sel_addr = start ? addr : lat_addr;

  always_comb begin
    if (rst || en_n) begin
      kind = ACC_IDLE;
    end else if (we_n) begin
      kind = ACC_READ;
    end else begin
      kind = ACC_WRITE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_hist  <= 1'b1;
      lat_addr <= '0;
    end else begin
      en_hist <= en_n;
      if (start) begin
        lat_addr <= addr;
      end
    end
  end

endmodule

// File: rtl/scrp_store.sv
module scrp_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] words;

  // one register per word, each with its own decoded write strobe
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(gi));
    always_ff @(posedge clk) begin
      if (hit) begin
        words[gi] <= wr_data;
      end
    end
  end

  assign rd_data = words[rd_addr];

endmodule

// File: rtl/scrp_out_stage.sv
module scrp_out_stage
  import scrp_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_kind_e         kind,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_oe <= 1'b0;
      dout    <= '0;
    end else if (kind == ACC_READ) begin
      dout_oe <= 1'b1;
      dout    <= ~rd_data;
    end else begin
      dout_oe <= 1'b0;
      dout    <= '0;
    end
  end

endmodule

// File: rtl/cmpl_scratchpad.sv
module cmpl_scratchpad
  import scrp_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  acc_kind_e         kind;
  logic [ADDR_W-1:0] sel_addr;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] rd_data;

  scrp_access_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .en_n     (en_n),
    .we_n     (we_n),
    .addr     (addr),
    .kind     (kind),
    .sel_addr (sel_addr),
    .lat_addr (lat_addr)
  );

  scrp_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .wr_en   (kind == ACC_WRITE),
    .wr_addr (sel_addr),
    .wr_data (din),
    .rd_addr (sel_addr),
    .rd_data (rd_data)
  );

  scrp_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .kind    (kind),
    .rd_data (rd_data),
    .dout    (dout),
    .dout_oe (dout_oe)
  );

endmodule

// File: rtl/cmpl_scratchpad_chk.sv
module cmpl_scratchpad_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              en_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] lat_addr,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe
);

  // edges since reset, saturating
  logic [1:0] n_ok;
  always_ff @(posedge clk) begin
    if (rst) begin
      n_ok <= '0;
    end else if (n_ok != 2'd3) begin
      n_ok <= n_ok + 2'd1;
    end
  end

  a_r2_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    (n_ok >= 2'd1 && $past(!en_n && we_n)) |-> dout_oe);

  a_r4_float_otherwise: assert property (@(posedge clk) disable iff (rst)
    (n_ok >= 2'd1 && $past(en_n || !we_n)) |-> (!dout_oe && dout == '0));

  a_r3_capture_on_fall: assert property (@(posedge clk) disable iff (rst)
    (n_ok >= 2'd2 && !$past(en_n) && $past(en_n, 2)) |-> (lat_addr == $past(addr)));

  a_r3_hold_while_low: assert property (@(posedge clk) disable iff (rst)
    (n_ok >= 2'd2 && !$past(en_n) && !$past(en_n, 2)) |-> $stable(lat_addr));

  a_r6_reread_stable: assert property (@(posedge clk) disable iff (rst)
    (n_ok >= 2'd2 && $past(!en_n && we_n) && $past(!en_n && we_n, 2)) |-> $stable(dout));

endmodule

bind cmpl_scratchpad cmpl_scratchpad_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en_n     (en_n),
  .we_n     (we_n),
  .addr     (addr),
  .lat_addr (lat_addr),
  .dout     (dout),
  .dout_oe  (dout_oe)
);

// File: tb/tb_cmpl_scratchpad.sv
`timescale 1ns/1ps
module tb_cmpl_scratchpad;

  localparam int AW = 4;
  localparam int DW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en_n = 1'b1;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_oe;

  always #4 clk = ~clk;

  cmpl_scratchpad #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .en_n(en_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // reference state built from the requirements
  logic [DW-1:0] m_mem [DEPTH];
  bit            m_valid [DEPTH];
  logic          m_hist = 1'b1;
  logic [AW-1:0] m_lat = '0;

  function automatic logic [DW-1:0] inv_of(logic [DW-1:0] w);
    return ~w;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // drive one cycle (called at a falling clock edge), then check the outputs
  task automatic tick(input logic e, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input string tag);
    logic fall;
    logic [AW-1:0] sel;
    logic exp_oe;
    logic known;
    logic [DW-1:0] exp_d;
    string t;
    en_n = e; we_n = w; addr = a; din = d;
    fall   = !e && m_hist;
    sel    = fall ? a : m_lat;
    exp_oe = !e && w;
    known  = !exp_oe || m_valid[sel];
    exp_d  = exp_oe ? inv_of(m_mem[sel]) : '0;
    if (!e && !w) begin
      m_mem[sel] = d;
      m_valid[sel] = 1'b1;
    end
    if (fall) m_lat = a;
    m_hist = e;
    @(negedge clk);
    t = (tag == "") ? (exp_oe ? "R2" : "R4") : tag;
    chk({t, " oe"}, {7'd0, dout_oe}, {7'd0, exp_oe});
    if (known) chk({t, " data"}, {4'd0, dout}, {4'd0, exp_d});
  endtask

  task automatic do_reset(input logic e, input int cycles);
    rst = 1'b1; en_n = e;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk("R9 oe in reset", {7'd0, dout_oe}, 8'd0);
      chk("R9 data in reset", {4'd0, dout}, 8'd0);
    end
    rst = 1'b0;
    m_hist = 1'b1;
    m_lat  = '0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0ffee5));
    for (int i = 0; i < DEPTH; i++) m_valid[i] = 1'b0;
    @(negedge clk);
    do_reset(1'b1, 3);

    // R1, R3, R8, R10: fill every word; addr wanders after the fall
    for (int i = 0; i < DEPTH; i++) begin
      tick(1'b1, 1'b1, '0, '0, "R5");
      tick(1'b0, 1'b0, AW'(i), 4'hF, "R1/R4");
      tick(1'b0, 1'b0, AW'(i + 5), DW'(i ^ 9), "R3/R8");
    end

    // R10, R6: read back each word, then read again with addr moved
    for (int i = 0; i < DEPTH; i++) begin
      tick(1'b1, 1'b1, '0, '0, "R4");
      tick(1'b0, 1'b1, AW'(i), '0, "R10");
      chk("R10 word", {4'd0, dout}, {4'd0, inv_of(DW'(i ^ 9))});
      tick(1'b0, 1'b1, ~AW'(i), '0, "R6");
    end

    // R5: write strobe with enable high stores nothing
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, 4'd3, 4'h0, "R5");
    tick(1'b0, 1'b1, 4'd3, '0, "R5");
    chk("R5 word kept", {4'd0, dout}, {4'd0, inv_of(4'd3 ^ 4'd9)});

    // R7: read-modify-write with the address moving between phases
    tick(1'b1, 1'b1, '0, '0, "R7");
    tick(1'b0, 1'b1, 4'd7, '0, "R7");
    tick(1'b0, 1'b0, 4'd9, 4'h5, "R7");
    tick(1'b0, 1'b1, 4'd9, '0, "R7");
    chk("R7 rmw readback", {4'd0, dout}, {4'd0, inv_of(4'h5)});
    tick(1'b1, 1'b1, '0, '0, "R7");
    tick(1'b0, 1'b1, 4'd9, '0, "R7");
    chk("R7 other word untouched", {4'd0, dout}, {4'd0, inv_of(4'd9 ^ 4'd9)});

    // R9: reset with enable held low, then read at once
    en_n = 1'b0; we_n = 1'b0; din = 4'h0; addr = 4'd5;
    do_reset(1'b0, 2);
    tick(1'b0, 1'b1, 4'd5, '0, "R9");
    chk("R9 fresh access after reset", {4'd0, dout}, {4'd0, inv_of(4'd5 ^ 4'd9)});

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic e, w;
      e = ($urandom_range(0, 3) == 0);
      w = ($urandom_range(0, 99) >= 35);
      tick(e, w, AW'($urandom), DW'($urandom), "");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule